// File: doc/BRIEF.md
# Byte-Stream to RAM Command Adapter

This block turns a sequence of bytes, such as the receive side of a serial link, into accesses on a simple SRAM-style port. The port is meant for a register bank that the rest of the chip cannot reach directly. Each access starts with a control byte. The top bit of that byte chooses between writing and reading. An address byte always follows it. For a write, a data byte comes last.

For a write, the block presents the address and data and pulses write enable for one clock. For a read, it presents the address. It then samples the RAM's combinational read data into an output byte, which is marked by a one-clock valid pulse that a transmitter can consume. The parser state is visible on a 2-bit output. A new control byte may arrive in the very cycle that the previous access is strobed.

Top module: `byte_ram_cmd_adapter`

## Requirements
- R1: While rst_ni is low, and at its release, state_o is 0, addr_o, wr_data_o and byte_o are 0, and wr_en_o and byte_vld_o are low.
- R2: A byte on byte_i is taken only on a rising clock edge where byte_vld_i is high. While byte_vld_i is low, state_o, addr_o and wr_data_o do not change.
- R3: The first byte of a transaction is a control byte. Bit 7 = 1 selects a write and bit 7 = 0 selects a read. Bits 6:0 have no effect. After the control byte, state_o is 1.
- R4: The byte after the control byte is the address. It appears on addr_o from the edge that takes it, for reads and for writes.
- R5: For a write, the byte after the address is the data byte. It appears on wr_data_o from the edge that takes it. Between the address and the data byte, state_o is 2.
- R6: wr_en_o is high for exactly one clock, in the cycle that follows the edge that takes the data byte. It is low at every other time.
- R7: For a read, state_o is 3 for the one cycle after the address byte is taken. On the next edge, byte_o takes the value of rd_data_i and byte_vld_o is high for exactly one cycle.
- R8: state_o uses 0 = await control, 1 = await address, 2 = await data, 3 = read response. After each completed transaction it returns to 0, unless the next control byte is taken at the same time.
- R9: A control byte may be taken in the cycle where wr_en_o is high, or in the cycle where state_o is 3. Either way the next transaction is decoded correctly, and the read response still occurs.
- R10: addr_o and wr_data_o keep their last values between transactions. A read does not change wr_data_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_i | input | 8 | Incoming command byte |
| byte_vld_i | input | 1 | Qualifies byte_i for one clock |
| rd_data_i | input | 8 | Combinational read data from the RAM |
| byte_o | output | 8 | Read response byte |
| byte_vld_o | output | 1 | One-clock pulse marking byte_o |
| addr_o | output | 8 | RAM address |
| wr_data_o | output | 8 | RAM write data |
| wr_en_o | output | 1 | One-clock RAM write strobe |
| state_o | output | 2 | Parser state |

## Verification
Two events can occur in the same cycle: the strobe of a finished transaction (wr_en_o after a data byte, or the read response that state 3 issues) and the acceptance of the next control byte. The bench provokes both cases by driving the next control byte immediately, with no idle gap. In the write case the control byte lands in the cycle where wr_en_o is high. In the read case it lands in the state-3 cycle. The bench then checks two things. First, the response byte equals the bench's own memory model at the read address. Second, the following transaction decodes to the correct state, address and data.

// File: rtl/byte_ram_adapter_pkg.sv
package byte_ram_adapter_pkg;
  typedef enum logic [1:0] {
    ST_CTRL = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_RESP = 2'd3
  } adp_state_e;
endpackage

// File: rtl/byte_cmd_fsm.sv
module byte_cmd_fsm
  import byte_ram_adapter_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic              addr_take_o,
  output logic              data_take_o,
  output logic              resp_fire_o,
  output adp_state_e        state_o
);
  localparam int FLAG_BIT = DATA_W - 1;

  adp_state_e st_q, st_d;
  logic       wr_flag_q;
  logic       ctrl_take;

  // a control byte may land while the read response is issued
  assign ctrl_take   = byte_vld_i && (st_q == ST_CTRL || st_q == ST_RESP);
  assign addr_take_o = byte_vld_i && (st_q == ST_ADDR);
  assign data_take_o = byte_vld_i && (st_q == ST_DATA);
  assign resp_fire_o = (st_q == ST_RESP);
  assign state_o     = st_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_CTRL: if (byte_vld_i) st_d = ST_ADDR;
      ST_ADDR: if (byte_vld_i) st_d = wr_flag_q ? ST_DATA : ST_RESP;
      ST_DATA: if (byte_vld_i) st_d = ST_CTRL;
      ST_RESP: st_d = byte_vld_i ? ST_ADDR : ST_CTRL;
      default: st_d = ST_CTRL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_CTRL;
      wr_flag_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (ctrl_take) wr_flag_q <= byte_i[FLAG_BIT];
    end
  end

  // R5
  data_only_on_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DATA) |-> wr_flag_q);
  // R7
  resp_only_on_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RESP) |-> !wr_flag_q);
  // R8
  resp_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RESP) |=> (st_q != ST_RESP));
endmodule

// File: rtl/byte_cmd_datapath.sv
module byte_cmd_datapath #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] byte_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              addr_take_i,
  input  logic              data_take_i,
  input  logic              resp_fire_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] rsp_o,
  output logic              rsp_vld_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o    <= '0;
      wr_data_o <= '0;
      wr_en_o   <= 1'b0;
      rsp_o     <= '0;
      rsp_vld_o <= 1'b0;
    end else begin
      if (addr_take_i) addr_o <= byte_i[ADDR_W-1:0];
      if (data_take_i) wr_data_o <= byte_i;
      wr_en_o   <= data_take_i;
      rsp_vld_o <= resp_fire_i;
      if (resp_fire_i) rsp_o <= rd_data_i;
    end
  end

  // R6
  wr_en_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);
  // R7
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_vld_o |=> !rsp_vld_o);
  // R10
  wdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_take_i |=> $stable(wr_data_o));
endmodule

// File: rtl/byte_ram_cmd_adapter.sv
module byte_ram_cmd_adapter
  import byte_ram_adapter_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [DATA_W-1:0] byte_o,
  output logic              byte_vld_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              wr_en_o,
  output logic [1:0]        state_o
);
  logic       addr_take, data_take, resp_fire;
  adp_state_e st;

  byte_cmd_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .byte_vld_i  (byte_vld_i),
    .byte_i      (byte_i),
    .addr_take_o (addr_take),
    .data_take_o (data_take),
    .resp_fire_o (resp_fire),
    .state_o     (st)
  );

  byte_cmd_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .byte_i      (byte_i),
    .rd_data_i   (rd_data_i),
    .addr_take_i (addr_take),
    .data_take_i (data_take),
    .resp_fire_i (resp_fire),
    .addr_o      (addr_o),
    .wr_data_o   (wr_data_o),
    .wr_en_o     (wr_en_o),
    .rsp_o       (byte_o),
    .rsp_vld_o   (byte_vld_o)
  );

  assign state_o = st;

  // R6
  wr_en_after_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> ($past(state_o) == 2'd2 && $past(byte_vld_i)));
  // R7
  rsp_after_resp_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |-> ($past(state_o) == 2'd3));
  // R9
  strobes_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_o && byte_vld_o));
  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!byte_vld_i && state_o != 2'd3) |=> $stable(state_o));
endmodule

// File: tb/byte_ram_cmd_adapter_tb.sv
module byte_ram_cmd_adapter_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] byte_i = '0;
  logic       byte_vld_i = 1'b0;
  logic [7:0] rd_data_i;
  logic [7:0] byte_o, addr_o, wr_data_o;
  logic       byte_vld_o, wr_en_o;
  logic [1:0] state_o;

  logic [7:0] mem [256];
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  byte_ram_cmd_adapter u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .byte_i(byte_i), .byte_vld_i(byte_vld_i),
    .rd_data_i(rd_data_i), .byte_o(byte_o), .byte_vld_o(byte_vld_o),
    .addr_o(addr_o), .wr_data_o(wr_data_o), .wr_en_o(wr_en_o), .state_o(state_o)
  );

  // bench RAM model: combinational read, clocked write
  assign rd_data_i = mem[addr_o];
  always @(posedge clk_i) if (wr_en_o) mem[addr_o] <= wr_data_o;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // called at a falling edge; returns at the falling edge after the accept edge
  task automatic send(logic [7:0] b);
    byte_i = b;
    byte_vld_i = 1'b1;
    @(negedge clk_i);
    byte_vld_i = 1'b0;
    byte_i = 8'hEE;
  endtask

  task automatic t_reset();
    chk("R1", "state", state_o, 0);
    chk("R1", "addr", addr_o, 0);
    chk("R1", "wdata", wr_data_o, 0);
    chk("R1", "byte_o", byte_o, 0);
    chk("R1", "strobes", {wr_en_o, byte_vld_o}, 0);
  endtask

  task automatic t_write(logic [7:0] ctrl, logic [7:0] a, logic [7:0] d);
    send(ctrl);
    chk("R3", "state after ctrl", state_o, 1);
    send(a);
    chk("R4", "addr on write", addr_o, a);
    chk("R5", "state await data", state_o, 2);
    chk("R6", "wr_en before data", wr_en_o, 0);
    send(d);
    chk("R5", "wdata", wr_data_o, d);
    chk("R6", "wr_en pulse", wr_en_o, 1);
    chk("R8", "state back to 0", state_o, 0);
  endtask

  task automatic t_read(logic [7:0] ctrl, logic [7:0] a);
    send(ctrl);
    chk("R3", "state after ctrl", state_o, 1);
    send(a);
    chk("R4", "addr on read", addr_o, a);
    chk("R7", "state resp", state_o, 3);
    chk("R7", "vld early", byte_vld_o, 0);
  endtask

  task automatic t_idle_gap();
    logic [7:0] a0, d0;
    logic [1:0] s0;
    a0 = addr_o; d0 = wr_data_o; s0 = state_o;
    byte_i = 8'hC3;
    repeat (3) @(negedge clk_i);
    chk("R2", "state while vld low", state_o, s0);
    chk("R2", "addr while vld low", addr_o, a0);
    chk("R10", "wdata held", wr_data_o, d0);
    chk("R6", "wr_en idle", wr_en_o, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i ^ 8'h5A);
    repeat (2) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();

    // plain write then strobe falls
    t_write(8'h80, 8'h12, 8'hA7);
    @(negedge clk_i);
    chk("R6", "wr_en low after one", wr_en_o, 0);
    t_idle_gap();

    // read of the written location, low bits of ctrl set (ignored)
    t_read(8'h7F, 8'h12);
    @(negedge clk_i);
    chk("R7", "read byte", byte_o, 8'hA7);
    chk("R7", "read vld", byte_vld_o, 1);
    chk("R8", "state after read", state_o, 0);
    chk("R10", "wdata unchanged by read", wr_data_o, 8'hA7);
    @(negedge clk_i);
    chk("R7", "read vld one cycle", byte_vld_o, 0);

    // write with all ctrl bits set, then control byte during wr_en cycle
    t_write(8'hFF, 8'h40, 8'h3C);
    send(8'h00);
    chk("R9", "ctrl during wr_en", state_o, 1);
    chk("R6", "wr_en dropped", wr_en_o, 0);
    send(8'h40);
    chk("R9", "read state", state_o, 3);
    // next control byte lands in the response cycle
    send(8'h81);
    chk("R9", "resp byte overlapped", byte_o, 8'h3C);
    chk("R9", "resp vld overlapped", byte_vld_o, 1);
    chk("R9", "state after overlap", state_o, 1);
    send(8'h99);
    chk("R9", "addr next write", addr_o, 8'h99);
    chk("R9", "await data", state_o, 2);
    send(8'h66);
    chk("R9", "wr_en next", wr_en_o, 1);
    chk("R9", "wdata next", wr_data_o, 8'h66);

    // read of an untouched location
    t_read(8'h00, 8'hF0);
    @(negedge clk_i);
    chk("R7", "read default", byte_o, 8'hF0 ^ 8'h5A);
    chk("R10", "addr held", addr_o, 8'hF0);
    t_idle_gap();
    summary();
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
  end
endmodule